// File: doc/BRIEF.md
# Instruction-Selected Scan Register Bank

This block is the data-register side of a user-defined scan port. An external scan controller supplies a parallel instruction value, the scan clock, serial input data and one-hot state strobes for instruction update, data capture, data shift and data update. The block latches the instruction, decodes it to choose one data chain, and places that chain between the serial input and the serial output. Every instruction code without an assigned chain routes through a one-bit pass-through register, so the serial path is never broken.

Two chains are assigned. The status chain is read-only and loads a value that the application drives from the system clock domain. The control chain is read/write: a data update copies the shifted value into a holding register, and a toggle handshake hands that value to the system clock domain as a parallel word with a one-cycle valid pulse. The scan clock may run at 10 MHz or below and has no phase relation to the system clock.

Top module: `dbgRegBank`

## Requirements
- R1: The instruction register loads `irValue` only on a scan clock edge where `stUpdateIr` is high; at all other edges the selected chain does not change. After reset the instruction is 0.
- R2: Instruction code 1 selects an 8-bit read-only status chain that loads the synchronized `statusIn` value on capture.
- R3: Instruction code 2 selects a 16-bit control chain that loads the last value written by a data update (0 after reset) on capture.
- R4: Every code other than 1 and 2 selects a one-bit pass-through register that loads 0 on capture, giving a serial delay of one shift.
- R5: Chains shift toward the least significant bit, one bit per scan clock edge with `stShift` high; new data enters at the most significant bit from `tdi`, and `tdo` shows bit 0 of the selected chain without a register stage.
- R6: A data update while code 2 is selected makes `ctrlOut` show the shifted 16-bit value together with a `ctrlValid` pulse one system clock cycle wide.
- R7: A data update while any other code is selected produces no `ctrlValid` pulse and leaves `ctrlOut` unchanged.
- R8: `statusIn` passes through a two-stage synchronizer on the scan clock, and the synchronized value does not change on an edge where `stCapture` is high.
- R9: After reset `tdo`, `ctrlOut` and `ctrlValid` are 0.
- R10: A chain keeps its contents on scan clock edges where neither capture nor shift applies to it, so shift cycles may be separated by idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock |
| tckRstN | input | 1 | Asynchronous active-low reset, scan domain |
| irValue | input | 4 | Parallel instruction value from the scan controller |
| stUpdateIr | input | 1 | Instruction update strobe |
| stCapture | input | 1 | Data capture strobe |
| stShift | input | 1 | Data shift strobe |
| stUpdateDr | input | 1 | Data update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| sysClk | input | 1 | System clock |
| sysRstN | input | 1 | Asynchronous active-low reset, system domain |
| statusIn | input | 8 | Status word from the system domain |
| ctrlOut | output | 16 | Last control word delivered to the system domain |
| ctrlValid | output | 1 | One-cycle pulse marking a new `ctrlOut` |

## Verification
The embedded assertions watch, on every cycle, that the instruction holds between update strobes, that the pass-through bit clears on capture, that the handshake toggle flips only on a control-chain update, that the synchronized status word is frozen during capture, that idle chains keep their contents and that the valid pulse is never wider than one cycle. Only the bench scenarios show the serial ordering of whole scans, the chain length seen for each of the 16 instruction codes, the read-back of written control values and the arrival of the word in the system domain; the bench sweeps every code with a distinct pattern and compares the full output stream against a computed model.

// File: rtl/dbgRegPkg.sv
package dbgRegPkg;

  // Strobes and chain selects handed from control to datapath
  typedef struct packed {
    logic capture;
    logic shift;
    logic update;
    logic selStatus;
    logic selCtrl;
    logic selBypass;
  } chainCtlT;

endpackage

// File: rtl/dbgScanCtrl.sv
module dbgScanCtrl
  import dbgRegPkg::*;
#(
  parameter int IR_W        = 4,
  parameter int STATUS_CODE = 1,
  parameter int CTRL_CODE   = 2
) (
  input  logic            tck,
  input  logic            rstN,
  input  logic [IR_W-1:0] irValue,
  input  logic            stUpdateIr,
  input  logic            stCapture,
  input  logic            stShift,
  input  logic            stUpdateDr,
  output chainCtlT        ctl
);

  localparam logic [IR_W-1:0] statusCode = IR_W'(STATUS_CODE);
  localparam logic [IR_W-1:0] ctrlCode   = IR_W'(CTRL_CODE);

  logic [IR_W-1:0] instReg;

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)           instReg <= '0;
    else if (stUpdateIr) instReg <= irValue;
  end

  logic hitStatus, hitCtrl;

  always_comb begin
    hitStatus     = (instReg == statusCode);
    hitCtrl       = (instReg == ctrlCode);
    ctl.capture   = stCapture;
    ctl.shift     = stShift;
    ctl.update    = stUpdateDr;
    ctl.selStatus = hitStatus;
    ctl.selCtrl   = hitCtrl;
    ctl.selBypass = !(hitStatus || hitCtrl);
  end

  // R1: instruction changes only on an update-IR edge
  a_r1_ir_hold: assert property (@(posedge tck) disable iff (!rstN)
    !stUpdateIr |=> $stable(instReg));

  // R5: scan strobes arrive one-hot
  a_r5_strobe_onehot: assert property (@(posedge tck) disable iff (!rstN)
    $onehot0({stUpdateIr, stCapture, stShift, stUpdateDr}));

  // R2: exactly one path selected
  a_r2_one_path: assert property (@(posedge tck) disable iff (!rstN)
    $onehot({ctl.selStatus, ctl.selCtrl, ctl.selBypass}));

endmodule

// File: rtl/dbgShiftChain.sv
module dbgShiftChain #(
  parameter int W = 8
) (
  input  logic         tck,
  input  logic         rstN,
  input  logic         capture,
  input  logic         shift,
  input  logic [W-1:0] capVal,
  input  logic         tdi,
  output logic [W-1:0] q
);

  logic [W-1:0] shiftNext;

  generate
    if (W > 1) begin : gWide
      assign shiftNext = {tdi, q[W-1:1]};
    end else begin : gSingle
      assign shiftNext = tdi;
    end
  endgenerate

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN)        q <= '0;
    else if (capture) q <= capVal;
    else if (shift)   q <= shiftNext;
  end

  // R10: chain holds when not addressed
  a_r10_idle_hold: assert property (@(posedge tck) disable iff (!rstN)
    (!capture && !shift) |=> $stable(q));

  // R5: new bit enters at the top
  a_r5_msb_entry: assert property (@(posedge tck) disable iff (!rstN)
    (shift && !capture) |=> (q[W-1] == $past(tdi)));

endmodule

// File: rtl/dbgScanPath.sv
module dbgScanPath
  import dbgRegPkg::*;
#(
  parameter int STAT_W = 8,
  parameter int CTRL_W = 16
) (
  input  logic              tck,
  input  logic              rstN,
  input  chainCtlT          ctl,
  input  logic              tdi,
  input  logic [STAT_W-1:0] statusTck,
  output logic              tdo,
  output logic [CTRL_W-1:0] ctrlHold,
  output logic              ctrlToggle
);

  logic [STAT_W-1:0] statusQ;
  logic [CTRL_W-1:0] ctrlQ;
  logic              bypassQ;

  dbgShiftChain #(.W(STAT_W)) uStatus (
    .tck(tck), .rstN(rstN),
    .capture(ctl.capture && ctl.selStatus),
    .shift(ctl.shift && ctl.selStatus),
    .capVal(statusTck), .tdi(tdi), .q(statusQ)
  );

  dbgShiftChain #(.W(CTRL_W)) uCtrl (
    .tck(tck), .rstN(rstN),
    .capture(ctl.capture && ctl.selCtrl),
    .shift(ctl.shift && ctl.selCtrl),
    .capVal(ctrlHold), .tdi(tdi), .q(ctrlQ)
  );

  dbgShiftChain #(.W(1)) uBypass (
    .tck(tck), .rstN(rstN),
    .capture(ctl.capture && ctl.selBypass),
    .shift(ctl.shift && ctl.selBypass),
    .capVal(1'b0), .tdi(tdi), .q(bypassQ)
  );

  always_ff @(posedge tck or negedge rstN) begin
    if (!rstN) begin
      ctrlHold   <= '0;
      ctrlToggle <= 1'b0;
    end else if (ctl.update && ctl.selCtrl) begin
      ctrlHold   <= ctrlQ;
      ctrlToggle <= !ctrlToggle;
    end
  end

  always_comb begin
    if (ctl.selStatus)    tdo = statusQ[0];
    else if (ctl.selCtrl) tdo = ctrlQ[0];
    else                  tdo = bypassQ;
  end

  // R4: pass-through bit reads 0 after capture
  a_r4_bypass_zero: assert property (@(posedge tck) disable iff (!rstN)
    (ctl.capture && ctl.selBypass) |=> (tdo == 1'b0));

  // R6: control update flips the handshake toggle
  a_r6_toggle_flip: assert property (@(posedge tck) disable iff (!rstN)
    (ctl.update && ctl.selCtrl) |=> (ctrlToggle != $past(ctrlToggle)));

  // R7: no other event touches the toggle
  a_r7_toggle_quiet: assert property (@(posedge tck) disable iff (!rstN)
    !(ctl.update && ctl.selCtrl) |=> $stable(ctrlToggle));

endmodule

// File: rtl/dbgCdc.sv
module dbgCdc #(
  parameter int STAT_W = 8,
  parameter int CTRL_W = 16,
  parameter int SYNC_N = 2
) (
  input  logic              tck,
  input  logic              tckRstN,
  input  logic              stCapture,
  input  logic [STAT_W-1:0] statusIn,
  output logic [STAT_W-1:0] statusTck,
  input  logic              sysClk,
  input  logic              sysRstN,
  input  logic              ctrlToggle,
  input  logic [CTRL_W-1:0] ctrlHold,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              ctrlValid
);

  localparam int TG_W = SYNC_N + 1;

  // Status: per-bit synchronizer on the scan clock, frozen during capture
  logic [STAT_W-1:0] statusMeta;

  always_ff @(posedge tck or negedge tckRstN) begin
    if (!tckRstN) begin
      statusMeta <= '0;
      statusTck  <= '0;
    end else begin
      statusMeta <= statusIn;
      if (!stCapture) statusTck <= statusMeta;
    end
  end

  // Control: toggle synchronizer plus edge detect in the system domain
  logic [TG_W-1:0] tgPipe;
  logic            tgEdge;

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) tgPipe <= '0;
    else          tgPipe <= {tgPipe[TG_W-2:0], ctrlToggle};
  end

  assign tgEdge = tgPipe[TG_W-1] ^ tgPipe[TG_W-2];

  always_ff @(posedge sysClk or negedge sysRstN) begin
    if (!sysRstN) begin
      ctrlOut   <= '0;
      ctrlValid <= 1'b0;
    end else begin
      ctrlValid <= tgEdge;
      if (tgEdge) ctrlOut <= ctrlHold;
    end
  end

  // R8: synchronized status frozen on capture edges
  a_r8_status_hold: assert property (@(posedge tck) disable iff (!tckRstN)
    stCapture |=> $stable(statusTck));

  // R6: valid is a single-cycle pulse
  a_r6_valid_single: assert property (@(posedge sysClk) disable iff (!sysRstN)
    ctrlValid |=> !ctrlValid);

  // R7: output word changes only with a valid pulse
  a_r7_out_quiet: assert property (@(posedge sysClk) disable iff (!sysRstN)
    !ctrlValid |-> $stable(ctrlOut) or $rose(ctrlValid));

endmodule

// File: rtl/dbgRegBank.sv
module dbgRegBank
  import dbgRegPkg::*;
#(
  parameter int IR_W        = 4,
  parameter int STAT_W      = 8,
  parameter int CTRL_W      = 16,
  parameter int STATUS_CODE = 1,
  parameter int CTRL_CODE   = 2
) (
  input  logic              tck,
  input  logic              tckRstN,
  input  logic [IR_W-1:0]   irValue,
  input  logic              stUpdateIr,
  input  logic              stCapture,
  input  logic              stShift,
  input  logic              stUpdateDr,
  input  logic              tdi,
  output logic              tdo,
  input  logic              sysClk,
  input  logic              sysRstN,
  input  logic [STAT_W-1:0] statusIn,
  output logic [CTRL_W-1:0] ctrlOut,
  output logic              ctrlValid
);

  chainCtlT          ctl;
  logic [STAT_W-1:0] statusTck;
  logic [CTRL_W-1:0] ctrlHold;
  logic              ctrlToggle;

  dbgScanCtrl #(
    .IR_W(IR_W), .STATUS_CODE(STATUS_CODE), .CTRL_CODE(CTRL_CODE)
  ) uCtrl (
    .tck(tck), .rstN(tckRstN), .irValue(irValue),
    .stUpdateIr(stUpdateIr), .stCapture(stCapture),
    .stShift(stShift), .stUpdateDr(stUpdateDr), .ctl(ctl)
  );

  dbgScanPath #(.STAT_W(STAT_W), .CTRL_W(CTRL_W)) uPath (
    .tck(tck), .rstN(tckRstN), .ctl(ctl), .tdi(tdi),
    .statusTck(statusTck), .tdo(tdo),
    .ctrlHold(ctrlHold), .ctrlToggle(ctrlToggle)
  );

  dbgCdc #(.STAT_W(STAT_W), .CTRL_W(CTRL_W), .SYNC_N(2)) uCdc (
    .tck(tck), .tckRstN(tckRstN), .stCapture(stCapture),
    .statusIn(statusIn), .statusTck(statusTck),
    .sysClk(sysClk), .sysRstN(sysRstN),
    .ctrlToggle(ctrlToggle), .ctrlHold(ctrlHold),
    .ctrlOut(ctrlOut), .ctrlValid(ctrlValid)
  );

endmodule

// File: tb/sim_dbgRegBank.sv
`timescale 1ns/1ps
module sim_dbgRegBank;

  localparam int NBITS = 24;

  logic        tck = 0, sysClk = 0;
  logic        tckRstN = 0, sysRstN = 0;
  logic [3:0]  irValue = '0;
  logic        stUpdateIr = 0, stCapture = 0, stShift = 0, stUpdateDr = 0;
  logic        tdi = 0;
  logic        tdo;
  logic [7:0]  statusIn = '0;
  logic [15:0] ctrlOut;
  logic        ctrlValid;

  int checks = 0, errors = 0, pulseCnt = 0, sysCycles = 0;

  always #5  sysClk = ~sysClk;
  always #50 tck = ~tck;

  dbgRegBank u0 (
    .tck(tck), .tckRstN(tckRstN), .irValue(irValue),
    .stUpdateIr(stUpdateIr), .stCapture(stCapture), .stShift(stShift),
    .stUpdateDr(stUpdateDr), .tdi(tdi), .tdo(tdo),
    .sysClk(sysClk), .sysRstN(sysRstN), .statusIn(statusIn),
    .ctrlOut(ctrlOut), .ctrlValid(ctrlValid)
  );

  always @(negedge sysClk) begin
    sysCycles++;
    if (ctrlValid) pulseCnt++;
    if (sysCycles > 150000) begin
      errors++;
      $display("FAIL watchdog: run did not end (actual %0d cycles, expected < 150000)", sysCycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic loadIr(input logic [3:0] v);
    irValue = v; stUpdateIr = 1;
    @(negedge tck); stUpdateIr = 0;
  endtask

  task automatic scanDr(input logic [NBITS-1:0] pat, input int gap, output logic [NBITS-1:0] got);
    stCapture = 1;
    @(negedge tck); stCapture = 0;
    for (int i = 0; i < NBITS; i++) begin
      if (gap > 0 && i == 7) begin
        stShift = 0;
        repeat (gap) @(negedge tck);
      end
      got[i] = tdo; tdi = pat[i]; stShift = 1;
      @(negedge tck);
    end
    stShift = 0;
    stUpdateDr = 1;
    @(negedge tck); stUpdateDr = 0;
    repeat (4) @(negedge tck);
  endtask

  function automatic logic [NBITS-1:0] expStream(input int len, input logic [15:0] cap, input logic [NBITS-1:0] pat);
    logic [NBITS-1:0] e;
    for (int i = 0; i < NBITS; i++) e[i] = (i < len) ? cap[i] : pat[i-len];
    return e;
  endfunction

  logic [15:0] holdModel = '0;
  logic [15:0] outModel = '0;

  task automatic runCode(input logic [3:0] code, input logic [3:0] latched, input int gap,
                         input logic [NBITS-1:0] pat, input string req);
    logic [NBITS-1:0] got, exp;
    int len;
    logic [15:0] cap;
    statusIn = 8'h3C + 8'(29 * code);
    repeat (3) @(negedge tck);
    loadIr(code);
    irValue = latched;
    len = (code == 1) ? 8 : (code == 2) ? 16 : 1;
    cap = (code == 1) ? {8'h0, statusIn} : (code == 2) ? holdModel : 16'h0;
    pulseCnt = 0;
    scanDr(pat, gap, got);
    exp = expStream(len, cap, pat);
    check(got == exp, req, 32'(got), 32'(exp));
    if (code == 2) begin
      holdModel = pat[NBITS-1:NBITS-16];
      outModel = holdModel;
      check(pulseCnt == 1, "R6 pulse count", 32'(pulseCnt), 32'd1);
      check(ctrlOut == outModel, "R6 ctrlOut", 32'(ctrlOut), 32'(outModel));
    end else begin
      check(pulseCnt == 0, "R7 pulse count", 32'(pulseCnt), 32'd0);
      check(ctrlOut == outModel, "R7 ctrlOut", 32'(ctrlOut), 32'(outModel));
    end
  endtask

  initial begin
    repeat (3) @(negedge tck);
    tckRstN = 1; sysRstN = 1;
    @(negedge tck);
    // R9: reset state
    check(tdo == 1'b0, "R9 tdo", 32'(tdo), 32'd0);
    check(ctrlOut == 16'h0, "R9 ctrlOut", 32'(ctrlOut), 32'd0);
    check(ctrlValid == 1'b0, "R9 ctrlValid", 32'(ctrlValid), 32'd0);

    // Sweep all codes: R2 status, R3 control, R4 bypass, R5 ordering
    for (int c = 0; c < 16; c++) begin
      logic [NBITS-1:0] pat;
      pat = 24'hA5C3E1 ^ NBITS'(c * 24'h13579B);
      if (c == 1)      runCode(4'(c), 4'(c), 0, pat, "R2 status scan");
      else if (c == 2) runCode(4'(c), 4'(c), 0, pat, "R3 control scan");
      else             runCode(4'(c), 4'(c), 0, pat, "R4 bypass scan");
    end

    // R3 read-back of a written control word, R5 LSB-first
    runCode(4'd2, 4'd2, 0, 24'h5AF0C3, "R3 readback R5");
    runCode(4'd2, 4'd2, 0, 24'h0FF00F, "R3 readback second");

    // R1: irValue changes without update-IR must not reselect
    runCode(4'd2, 4'd1, 0, 24'h31415F, "R1 ir held ctrl");
    runCode(4'd2, 4'd2, 0, 24'h271828, "R1 ir still ctrl");
    runCode(4'd1, 4'd9, 0, 24'h123456, "R1 ir held status");

    // R10: idle cycles in the middle of a shift
    runCode(4'd2, 4'd2, 5, 24'h9BDF13, "R10 gap ctrl");
    runCode(4'd1, 4'd1, 3, 24'hC0FFEE, "R10 gap status");
    runCode(4'd7, 4'd7, 4, 24'hBEEF01, "R10 gap bypass");

    // R8: status changes reach the chain after synchronization
    runCode(4'd1, 4'd1, 0, 24'h000000, "R8 status sync");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule